// File: doc/BRIEF.md
# 32-Pin GPIO Port with Per-Pin Interrupt Detection

This block is a general-purpose I/O port of 32 pins behind a small register bus (byte address, write data, write strobe, combinational read data). Each pin can be driven by the port or left as an input. The data and direction registers go straight out to the pad drivers. Every pad input is brought into the clock domain through a two-stage synchronizer. A third register keeps the synchronized value from the cycle before, so that edges can be detected.

Each pin carries a 2-bit trigger mode. The modes of the lower half of the pins are packed in one configuration register and those of the upper half in a second one. A per-pin any-edge bit overrides that mode. Detected conditions are latched in a sticky status register whether or not the pin is masked. Software clears status bits by writing ones. A single interrupt line is raised while any pin has both its status bit and its mask bit set.

Top module: `gpio_irq_port`

## Requirements
- R1: After a synchronous active-low reset, the data, direction, both mode registers, the mask and the any-edge register read 0. `pad_out` and `pad_oe` are 0 and `irq` is 0.
- R2: `pad_oe` bit n follows direction bit n (1 = output, 0 = input). `pad_out` bit n follows data bit n (1 = high, 0 = low). Both take a written value one clock after the write.
- R3: Pad inputs reach the pad-state register (offset 0x08) two clocks after they change. Writes to that offset change nothing. A read of the data register (offset 0x00) returns the driven value for output pins and the synchronized pad value for input pins.
- R4: The mode of pin n is the 2-bit field at bit 2×(n mod 16). For pins 0–15 the field is in the register at 0x0C, and for pins 16–31 it is in the register at 0x10. Code 00 triggers while the synchronized pin is low and 01 triggers while it is high.
- R5: Code 10 triggers on a rising edge and code 11 on a falling edge. An edge is a difference between the synchronized value and its value one clock earlier, so the status bit sets three clocks after the pad changes. The opposite edge does not trigger.
- R6: While bit n of the any-edge register (0x1C) is 1, pin n triggers on both edges and never on a level, whatever its mode field holds.
- R7: The status register (0x18) sets bit n on a trigger of pin n regardless of the mask. A bit stays set until a write with a 1 in that position. Bits written 0 are unchanged.
- R8: If a clear and a trigger of the same pin fall in the same cycle, an edge trigger wins and the bit stays set. A level trigger yields, so the bit reads 0 for that one cycle and sets again on the next clock if the level persists.
- R9: `irq` is 1 exactly when some pin has both its status bit and its mask bit (0x14) set. With the reset mask of 0, `irq` stays low.
- R10: Registers sit at word offsets 0x00 data, 0x04 direction, 0x08 pad state, 0x0C low-pin modes, 0x10 high-pin modes, 0x14 mask, 0x18 status, 0x1C any-edge. An address with bit 1 or bit 0 set reads 0 and a write to it is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on `bus_addr` |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Levels driven towards the pads |
| pad_oe | output | 32 | Output enables, 1 = pin driven |
| irq | output | 1 | Combined interrupt request |

## Verification
A software clear of a status bit can land in the very cycle in which the same pin produces a new trigger. The bench provokes this by starting a clear write exactly two clocks after a pad change, so that the write edge is the edge on which the detected transition is latched. It then reads the bit back, expecting it still set for an edge and briefly cleared for a level. A behavioural model in the bench predicts every register, the pad outputs and the interrupt on every clock, including a stretch of pseudo-random pad activity mixed with random writes and clears.

// File: rtl/gpio_irq_pkg.sv
// Package: shared constants and encodings for the GPIO interrupt port.
// Assumes a 32-bit register bus with byte addressing of word registers.
package gpio_irq_pkg;

    localparam int PORT_PINS = 32;
    localparam int BUS_AW    = 5;

    // Word index of each register (byte address bits [4:2]).
    typedef enum logic [2:0] {
        REG_DATA   = 3'd0,
        REG_DIR    = 3'd1,
        REG_PAD    = 3'd2,
        REG_MODE_L = 3'd3,
        REG_MODE_H = 3'd4,
        REG_MASK   = 3'd5,
        REG_STAT   = 3'd6,
        REG_ANYE   = 3'd7
    } reg_idx_e;

    // Per-pin trigger mode; the code values are software visible.
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_mode_e;

endpackage

// File: rtl/gpio_in_sync.sv
// Module: gpio_in_sync
// Brings asynchronous pad levels into the clock domain with two flops and
// keeps a third copy holding the synchronized value of the previous cycle.
// Assumes pads may change at any time; outputs are glitch-free registers.
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] sync_now,
    output logic [WIDTH-1:0] sync_prev
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] now_q;
    logic [WIDTH-1:0] prev_q;
    logic [1:0]       warm_q;

    // Synchronizer chain plus one-cycle history register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            now_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            now_q  <= meta_q;
            prev_q <= now_q;
        end
    end

    // Counts the first cycles after reset so the latency check starts clean.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    assign sync_now  = now_q;
    assign sync_prev = prev_q;

    AST_SYNC_TWO_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (sync_now == $past(pad_in, 2))); // R3

endmodule

// File: rtl/gpio_trig_detect.sv
// Module: gpio_trig_detect
// Per-pin trigger decode: selects each pin's 2-bit mode from the low or high
// mode register and evaluates level or edge conditions; the any-edge bit
// overrides the mode. Purely combinational.
// Assumes WIDTH is even; pins below WIDTH/2 use the low mode register.
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] sync_now,
    input  logic [WIDTH-1:0] sync_prev,
    input  logic [WIDTH-1:0] mode_lo,
    input  logic [WIDTH-1:0] mode_hi,
    input  logic [WIDTH-1:0] any_edge,
    output logic [WIDTH-1:0] trig,
    output logic [WIDTH-1:0] trig_is_level
);

    localparam int HALF = WIDTH / 2;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic [1:0] fld;
        logic       t_i;
        logic       lv_i;

        if (i < HALF) begin : g_lo
            assign fld = mode_lo[2*i +: 2];
        end else begin : g_hi
            assign fld = mode_hi[2*(i-HALF) +: 2];
        end

        // Evaluate this pin's trigger condition under its effective mode.
        always_comb begin
            t_i  = 1'b0;
            lv_i = 1'b0;
            if (any_edge[i]) begin
                t_i = sync_now[i] ^ sync_prev[i];
            end else begin
                case (trig_mode_e'(fld))
                    TRIG_LOW: begin
                        t_i  = ~sync_now[i];
                        lv_i = 1'b1;
                    end
                    TRIG_HIGH: begin
                        t_i  = sync_now[i];
                        lv_i = 1'b1;
                    end
                    TRIG_RISE: t_i = sync_now[i] & ~sync_prev[i];
                    default:   t_i = ~sync_now[i] & sync_prev[i];
                endcase
            end
        end

        assign trig[i]          = t_i;
        assign trig_is_level[i] = lv_i;
    end

endmodule

// File: rtl/gpio_stat_latch.sv
// Module: gpio_stat_latch
// Sticky per-pin status with write-one-to-clear. A clear in the same cycle
// as an edge trigger loses; against a level trigger it wins for one cycle.
// Assumes clr is a one-cycle pulse vector from the register bus.
module gpio_stat_latch #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] trig,
    input  logic [WIDTH-1:0] trig_is_level,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] status
);

    logic [WIDTH-1:0] stat_q;
    logic [WIDTH-1:0] stat_d;

    // Next status: keep uncleared bits, add triggers not overridden by a clear.
    always_comb begin
        stat_d = (stat_q & ~clr) | (trig & ~(clr & trig_is_level));
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign status = stat_q;

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~trig)) |=> ((status & $past(clr & ~trig)) == '0)); // R7
    AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status & ~clr)) |=> ((status & $past(status & ~clr)) == $past(status & ~clr))); // R7
    AST_EDGE_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (|(trig & ~trig_is_level)) |=> ((status & $past(trig & ~trig_is_level)) == $past(trig & ~trig_is_level))); // R8
    AST_LEVEL_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(trig & trig_is_level & clr)) |=> ((status & $past(trig & trig_is_level & clr)) == '0)); // R8

endmodule

// File: rtl/gpio_irq_port.sv
// Module: gpio_irq_port (top)
// 32-pin GPIO port: register bank on a simple bus, pad output drive,
// synchronized pad sampling, per-pin trigger detection, sticky status and a
// masked, OR-combined interrupt output.
// Assumes one bus write per clock, word-aligned accesses; reads are
// combinational on the address.
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = PORT_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPIN-1:0]   bus_wdata,
    output logic [NPIN-1:0]   bus_rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic              irq
);

    logic [NPIN-1:0] dout_q;
    logic [NPIN-1:0] dir_q;
    logic [NPIN-1:0] mode_lo_q;
    logic [NPIN-1:0] mode_hi_q;
    logic [NPIN-1:0] mask_q;
    logic [NPIN-1:0] anye_q;
    logic [NPIN-1:0] sync_now;
    logic [NPIN-1:0] sync_prev;
    logic [NPIN-1:0] trig;
    logic [NPIN-1:0] trig_lv;
    logic [NPIN-1:0] status;
    logic [NPIN-1:0] clr_vec;
    logic            aligned;
    reg_idx_e        sel;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign sel     = reg_idx_e'(bus_addr[4:2]);

    // Writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q    <= '0;
            dir_q     <= '0;
            mode_lo_q <= '0;
            mode_hi_q <= '0;
            mask_q    <= '0;
            anye_q    <= '0;
        end else if (bus_we && aligned) begin
            case (sel)
                REG_DATA:   dout_q    <= bus_wdata;
                REG_DIR:    dir_q     <= bus_wdata;
                REG_MODE_L: mode_lo_q <= bus_wdata;
                REG_MODE_H: mode_hi_q <= bus_wdata;
                REG_MASK:   mask_q    <= bus_wdata;
                REG_ANYE:   anye_q    <= bus_wdata;
                default:    ;
            endcase
        end
    end

    // Write-one-to-clear pulse towards the status latch.
    always_comb begin
        clr_vec = '0;
        if (bus_we && aligned && (sel == REG_STAT)) begin
            clr_vec = bus_wdata;
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (sel)
                REG_DATA:   bus_rdata = (dir_q & dout_q) | (~dir_q & sync_now);
                REG_DIR:    bus_rdata = dir_q;
                REG_PAD:    bus_rdata = sync_now;
                REG_MODE_L: bus_rdata = mode_lo_q;
                REG_MODE_H: bus_rdata = mode_hi_q;
                REG_MASK:   bus_rdata = mask_q;
                REG_STAT:   bus_rdata = status;
                default:    bus_rdata = anye_q;
            endcase
        end
    end

    gpio_in_sync #(.WIDTH(NPIN)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_in    (pad_in),
        .sync_now  (sync_now),
        .sync_prev (sync_prev)
    );

    gpio_trig_detect #(.WIDTH(NPIN)) u_detect (
        .sync_now      (sync_now),
        .sync_prev     (sync_prev),
        .mode_lo       (mode_lo_q),
        .mode_hi       (mode_hi_q),
        .any_edge      (anye_q),
        .trig          (trig),
        .trig_is_level (trig_lv)
    );

    gpio_stat_latch #(.WIDTH(NPIN)) u_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .trig          (trig),
        .trig_is_level (trig_lv),
        .clr           (clr_vec),
        .status        (status)
    );

    assign pad_out = dout_q;
    assign pad_oe  = dir_q;
    assign irq     = |(status & mask_q);

    AST_MASK_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq); // R9
    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && aligned && (sel == REG_DIR)) |=> (pad_oe == $past(bus_wdata))); // R2
    AST_MISALIGNED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !aligned) |=> ($stable(pad_out) && $stable(pad_oe))); // R10

endmodule

// File: tb/sim_gpio_irq_port.sv
// Bench: behavioural reference model compared on every clock, plus
// directed sequences for each requirement.
module sim_gpio_irq_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic started = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_port u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_dout, m_dir, m_lo, m_hi, m_mask, m_stat, m_anye;
    logic [31:0] m_p1, m_p2, m_p3;
    logic [31:0] m_trig, m_lvl, m_clr, m_next;

    function automatic int mode_of(input int pin);
        if (pin < 16) return int'((m_lo >> (2 * pin)) & 32'd3);
        return int'((m_hi >> (2 * (pin - 16))) & 32'd3);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dout <= '0; m_dir <= '0; m_lo <= '0; m_hi <= '0;
            m_mask <= '0; m_stat <= '0; m_anye <= '0;
            m_p1 <= '0; m_p2 <= '0; m_p3 <= '0;
        end else begin
            m_trig = '0;
            m_lvl  = '0;
            for (int i = 0; i < 32; i++) begin
                if (m_anye[i]) begin
                    m_trig[i] = (m_p2[i] != m_p3[i]);
                end else begin
                    case (mode_of(i))
                        0: begin m_trig[i] = !m_p2[i]; m_lvl[i] = 1'b1; end
                        1: begin m_trig[i] = m_p2[i];  m_lvl[i] = 1'b1; end
                        2: m_trig[i] = m_p2[i] && !m_p3[i];
                        default: m_trig[i] = !m_p2[i] && m_p3[i];
                    endcase
                end
            end
            m_clr = '0;
            if (bus_we && bus_addr[1:0] == 2'b00) begin
                case (bus_addr[4:2])
                    3'd0: m_dout <= bus_wdata;
                    3'd1: m_dir  <= bus_wdata;
                    3'd3: m_lo   <= bus_wdata;
                    3'd4: m_hi   <= bus_wdata;
                    3'd5: m_mask <= bus_wdata;
                    3'd6: m_clr = bus_wdata;
                    3'd7: m_anye <= bus_wdata;
                    default: ;
                endcase
            end
            for (int i = 0; i < 32; i++) begin
                if (m_clr[i]) m_next[i] = m_trig[i] && !m_lvl[i];
                else          m_next[i] = m_stat[i] || m_trig[i];
            end
            m_stat <= m_next;
            m_p1 <= pad_in;
            m_p2 <= m_p1;
            m_p3 <= m_p2;
        end
    end

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        if (a[1:0] != 2'b00) return '0;
        case (a[4:2])
            3'd0: return (m_dir & m_dout) | (~m_dir & m_p2);
            3'd1: return m_dir;
            3'd2: return m_p2;
            3'd3: return m_lo;
            3'd4: return m_hi;
            3'd5: return m_mask;
            3'd6: return m_stat;
            default: return m_anye;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        if (a[1:0] != 2'b00) return "R10";
        case (a[4:2])
            3'd1: return "R2";
            3'd3, 3'd4: return "R4";
            3'd5: return "R9";
            3'd6: return "R7";
            3'd7: return "R6";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison of every output against the model.
    always @(negedge clk) begin
        if (started) begin
            chk(tag_of(bus_addr), bus_rdata, exp_read(bus_addr));
            chk("R2 pad_out", pad_out, m_dout);
            chk("R2 pad_oe", pad_oe, m_dir);
            chk("R9 irq", {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] m, input logic [31:0] e, input string tag);
        bus_addr = a;
        @(negedge clk);
        chk(tag, bus_rdata & m, e);
        @(posedge clk); #1;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        chk(tag, {31'd0, irq}, {31'd0, e});
        @(posedge clk); #1;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        summary();
        $finish;
    end

    logic [31:0] rnd = 32'h1ACE_B00C;
    task automatic nxt();
        rnd = rnd ^ (rnd << 13);
        rnd = rnd ^ (rnd >> 17);
        rnd = rnd ^ (rnd << 5);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        started = 1'b1;
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 pad_out", pad_out, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);
        @(posedge clk); #1;
        rd(5'h14, 32'hFFFF_FFFF, 32'h0, "R1 mask");
        rd(5'h04, 32'hFFFF_FFFF, 32'h0, "R1 dir");
        rd(5'h1C, 32'hFFFF_FFFF, 32'h0, "R1 anyedge");
        rd(5'h0C, 32'hFFFF_FFFF, 32'h0, "R1 mode_lo");

        // R2 / R10 drive and direction
        wr(5'h00, 32'hA5A5_0F0F);
        wr(5'h04, 32'hFFFF_0000);
        @(negedge clk);
        chk("R2 out", pad_out, 32'hA5A5_0F0F);
        chk("R2 oe", pad_oe, 32'hFFFF_0000);
        @(posedge clk); #1;
        rd(5'h00, 32'hFFFF_FFFF, 32'hA5A5_0000, "R3 mixed read");
        rd(5'h02, 32'hFFFF_FFFF, 32'h0, "R10 misaligned read");
        wr(5'h01, 32'h0);
        rd(5'h04, 32'hFFFF_FFFF, 32'hFFFF_0000, "R10 misaligned write ignored");

        // R3 synchronizer latency
        pad_in = 32'h0000_1234;
        bus_addr = 5'h08;
        @(negedge clk); chk("R3 latency0", bus_rdata, 32'h0);
        @(posedge clk); #1;
        @(negedge clk); chk("R3 latency1", bus_rdata, 32'h0);
        @(posedge clk); #1;
        @(negedge clk); chk("R3 latency2", bus_rdata, 32'h0000_1234);
        @(posedge clk); #1;
        rd(5'h00, 32'hFFFF_FFFF, 32'hA5A5_1234, "R3 data read");
        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h08, 32'hFFFF_FFFF, 32'h0000_1234, "R3 pad write ignored");

        // R4 / R8 low level yields to clear, then re-sets
        wr(5'h0C, 32'hAAAA_AA1E);
        wr(5'h10, 32'hAAAA_AAAB);
        pad_in = 32'h0;
        step(4);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, 32'hFFFF_FFFF, 32'h0, "R8 level cleared one cycle");
        rd(5'h18, 32'hFFFF_FFFF, 32'h8, "R4 low level re-sets");

        // R4 high level
        pad_in = 32'h4;
        step(3);
        rd(5'h18, 32'h4, 32'h4, "R4 high level");
        pad_in = 32'h0;
        step(3);
        wr(5'h18, 32'h4);
        rd(5'h18, 32'h4, 32'h0, "R7 clear");

        // R5 rising / falling
        wr(5'h18, 32'hFFFF_FFFF);
        pad_in = 32'h3;
        step(4);
        rd(5'h18, 32'h3, 32'h1, "R5 rise");
        wr(5'h18, 32'h3);
        pad_in = 32'h0;
        step(4);
        rd(5'h18, 32'h3, 32'h2, "R5 fall");

        // R4 upper-half field placement
        wr(5'h18, 32'hFFFF_FFFF);
        pad_in = 32'h0003_0000;
        step(4);
        rd(5'h18, 32'h0003_0000, 32'h0002_0000, "R4 hi rise");
        pad_in = 32'h0;
        step(4);
        rd(5'h18, 32'h0003_0000, 32'h0003_0000, "R4 hi fall");

        // R6 any-edge override
        wr(5'h1C, 32'h1);
        wr(5'h18, 32'hFFFF_FFFF);
        pad_in = 32'h1;
        step(4);
        rd(5'h18, 32'h1, 32'h1, "R6 any rise");
        wr(5'h18, 32'h1);
        pad_in = 32'h0;
        step(4);
        rd(5'h18, 32'h1, 32'h1, "R6 any fall");
        wr(5'h1C, 32'h8);
        wr(5'h18, 32'hFFFF_FFFF);
        step(2);
        rd(5'h18, 32'h8, 32'h0, "R6 level suppressed");
        wr(5'h1C, 32'h0);

        // R7 / R9 mask independence and interrupt
        pad_in = 32'h0002_0000;
        step(4);
        wr(5'h18, 32'h0);
        rd(5'h18, 32'h0002_0000, 32'h0002_0000, "R7 zero write no effect");
        chk_irq(1'b0, "R9 masked");
        wr(5'h14, 32'h0002_0000);
        chk_irq(1'b1, "R9 unmasked");
        wr(5'h18, 32'h0002_0000);
        chk_irq(1'b0, "R9 after clear");

        // R8 clear and edge trigger in the same cycle
        wr(5'h14, 32'h1);
        pad_in = 32'h0002_0001;
        @(posedge clk);
        @(posedge clk); #1;
        bus_addr = 5'h18; bus_wdata = 32'h1; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
        rd(5'h18, 32'h1, 32'h1, "R8 edge wins");
        chk_irq(1'b1, "R8 irq stays");

        // Mixed pseudo-random traffic checked by the model every clock
        for (int n = 0; n < 400; n++) begin
            nxt();
            pad_in = rnd;
            nxt();
            bus_addr = {rnd[7:5], (rnd[9] ? rnd[11:10] : 2'b00)};
            nxt();
            bus_wdata = rnd;
            bus_we = rnd[3] & rnd[4];
            @(posedge clk); #1;
        end
        bus_we = 1'b0;
        step(2);

        summary();
        $finish;
    end

endmodule